// File: doc/BRIEF.md
# Processor Store Buffer with Fence

This block sits between a processor pipeline and its data cache. A store hands over an address, a data word and a one-bit cache-ready hint, and it retires at once. The cache need not be ready and the line may miss. The buffer keeps up to `DEPTH` pending stores and writes them to the cache in the background through a valid/ready write port. A load address is searched against every pending store in the same cycle. When several pending stores match, the youngest one supplies the data. The pipeline uses that data in place of the cache's answer.

The parameter `MODE` sets the drain policy. `DRAIN_IN_ORDER` writes stores to the cache strictly oldest first. `DRAIN_ANY_ORDER` writes first the oldest pending store whose hint was set when it entered. A store with the hint set is one the cache is expected to accept quickly. When no pending store has the hint, this mode falls back to the oldest store. A fence request input raises a stall output for as long as any store is still pending.

Back-pressure rules. The store port accepts a store in a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low only when the buffer is full, and it does not depend on the cache port in the same cycle. The cache write port presents a store whenever the buffer is not empty. Once `cw_valid` is high and `cw_ready` is low, the presented address and data stay unchanged until `cw_ready` rises. A cache write and a new store may complete in the same cycle.

Top module: `wbuf_top`

## Requirements
- R1: `st_ready` is high exactly when fewer than `DEPTH` stores are pending. A store offered while `st_ready` is low is not taken.
- R2: `cw_valid` is high exactly when at least one store is pending. While `cw_valid` is high and `cw_ready` is low, `cw_addr` and `cw_data` hold their values into the next cycle.
- R3: `ld_hit` is high when some pending store has an address equal to `ld_addr`. `ld_data` then equals the data of the most recently accepted of those stores. The search covers only stores accepted before the current cycle.
- R4: With `MODE = DRAIN_IN_ORDER`, the sequence of completed cache writes equals the sequence of accepted stores.
- R5: With `MODE = DRAIN_ANY_ORDER`, the store presented to the cache is the oldest pending store whose hint (`st_hint` = 1 at acceptance) was set. If no pending store has the hint, the oldest pending store is presented. A store already presented while stalled stays presented.
- R6: `fence_stall` is high when `fence_req` is high and at least one store is pending. It is low otherwise.
- R7: After reset the buffer is empty: `st_ready` = 1, `cw_valid` = 0, `ld_hit` = 0, and `fence_stall` = 0 even with `fence_req` = 1.
- R8: When a store is accepted and a cache write completes in the same cycle, both take effect. The removed store leaves the buffer and the new store joins it as the youngest.
- R9: When no pending store matches `ld_addr`, `ld_hit` = 0 and `ld_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_hint | input | 1 | Cache expects to accept this line quickly |
| ld_addr | input | AW | Load address to search |
| ld_hit | output | 1 | A pending store matches the load |
| ld_data | output | DW | Forwarded data from the youngest match |
| fence_req | input | 1 | Pipeline is at a fence |
| fence_stall | output | 1 | Hold the pipeline at the fence |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |

## Verification
The bench drives one in-order instance and one any-order instance with the same stimulus. A first pattern holds the cache port stalled while stores fill the buffer. Loads then hit repeated addresses, which separates youngest-match forwarding from oldest-match forwarding and shows the full-buffer stall. A fence phase then drains the buffer with an intermittent `cw_ready`, so a stall that releases too early shows up. A long random phase mixes hints, stalls and loads, which separates hint-first picking from strict order and exposes a drain choice that moves while stalled. A closing burst keeps store and cache handshakes going in the same cycles.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic {
    DRAIN_IN_ORDER  = 1'b0,
    DRAIN_ANY_ORDER = 1'b1
  } drain_mode_e;

endpackage

// File: rtl/wbuf_pick.sv
// Returns the index of the oldest set candidate bit; zero when none is set.
module wbuf_pick #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wbuf_search.sv
// Youngest-match search over age-ordered entries (index 0 oldest).
module wbuf_search #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0] live,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  input  logic [AW-1:0]    key,
  output logic             hit,
  output logic [DW-1:0]    data
);
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && ent_addr[i] == key) begin
        hit  = 1'b1;
        data = ent_data[i];
      end
    end
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int          DEPTH = 8,
  parameter int          AW    = 32,
  parameter int          DW    = 32,
  parameter drain_mode_e MODE  = DRAIN_IN_ORDER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_hint,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          fence_req,
  output logic          fence_stall,
  output logic          cw_valid,
  input  logic          cw_ready,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  // Age-ordered storage: slot 0 is the oldest, slots below cnt_q are live.
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] hint_q;
  logic [AW-1:0]    addr_d [DEPTH];
  logic [DW-1:0]    data_d [DEPTH];
  logic [DEPTH-1:0] hint_d;
  logic [CW-1:0]    cnt_q, cnt_rem;
  logic [DEPTH-1:0] live, cand;
  logic [IW-1:0]    pick_idx, sel_idx, hold_idx_q;
  logic             hold_q, drain, enq;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) live[i] = CW'(i) < cnt_q;
  end

  // Drain policy: in-order mode offers no candidates, so slot 0 is chosen.
  assign cand = (MODE == DRAIN_ANY_ORDER) ? (live & hint_q) : '0;

  wbuf_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .cand (cand),
    .idx  (pick_idx)
  );

  // A choice presented under back-pressure is kept until accepted.
  assign sel_idx  = hold_q ? hold_idx_q : pick_idx;
  assign cw_valid = cnt_q != '0;
  assign cw_addr  = addr_q[sel_idx];
  assign cw_data  = data_q[sel_idx];

  wbuf_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .live     (live),
    .ent_addr (addr_q),
    .ent_data (data_q),
    .key      (ld_addr),
    .hit      (ld_hit),
    .data     (ld_data)
  );

  assign st_ready    = cnt_q != CW'(DEPTH);
  assign fence_stall = fence_req && cnt_q != '0;
  assign drain       = cw_valid && cw_ready;
  assign enq         = st_valid && st_ready;
  assign cnt_rem     = cnt_q - CW'(drain);

  // Next state per slot: close the gap left by a drain, then append.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_comb begin
      addr_d[g] = addr_q[g];
      data_d[g] = data_q[g];
      hint_d[g] = hint_q[g];
      if (CW'(g) < cnt_rem) begin
        if (drain && IW'(g) >= sel_idx) begin
          if (g < DEPTH - 1) begin
            addr_d[g] = addr_q[(g < DEPTH - 1) ? g + 1 : g];
            data_d[g] = data_q[(g < DEPTH - 1) ? g + 1 : g];
            hint_d[g] = hint_q[(g < DEPTH - 1) ? g + 1 : g];
          end
        end
      end else if (enq && CW'(g) == cnt_rem) begin
        addr_d[g] = st_addr;
        data_d[g] = st_data;
        hint_d[g] = st_hint;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      addr_q[i] <= addr_d[i];
      data_q[i] <= data_d[i];
    end
    hint_q <= hint_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      cnt_q      <= cnt_rem + CW'(enq);
      hold_q     <= cw_valid && !cw_ready;
      hold_idx_q <= sel_idx;
    end
  end

  // A refused store must not grow the buffer.
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (cnt_q <= $past(cnt_q)));

  // Back-pressure on the cache port keeps the offered write steady.
  assert_cw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data)));

  // Forwarding can only happen from a non-empty buffer.
  assert_fwd_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> cw_valid);

  // A fence releases only once nothing is left to drain.
  assert_fence_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req && !fence_stall) |-> !cw_valid);

endmodule

// File: tb/wbuf_top_test.sv
module wbuf_top_test;
  import wbuf_pkg::*;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    bit          h;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
  logic        st_hint = 1'b0, fence_req = 1'b0;
  logic        cw_rdy [2];
  logic        st_rdy [2], ldh [2], fst [2], cwv [2];
  logic [31:0] ldd [2], cwa [2], cwd [2];

  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  ent_t mq [2][$];
  bit   mhold [2];
  int   midx [2];
  bit   both_prev [2];

  always #(PERIOD/2) clk = ~clk;

  wbuf_top #(.DEPTH(DEPTH), .AW(32), .DW(32), .MODE(DRAIN_IN_ORDER)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_rdy[0]),
    .st_addr(st_addr), .st_data(st_data), .st_hint(st_hint), .ld_addr(ld_addr),
    .ld_hit(ldh[0]), .ld_data(ldd[0]), .fence_req(fence_req), .fence_stall(fst[0]),
    .cw_valid(cwv[0]), .cw_ready(cw_rdy[0]), .cw_addr(cwa[0]), .cw_data(cwd[0])
  );

  wbuf_top #(.DEPTH(DEPTH), .AW(32), .DW(32), .MODE(DRAIN_ANY_ORDER)) uut_rc (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_rdy[1]),
    .st_addr(st_addr), .st_data(st_data), .st_hint(st_hint), .ld_addr(ld_addr),
    .ld_hit(ldh[1]), .ld_data(ldd[1]), .fence_req(fence_req), .fence_stall(fst[1]),
    .cw_valid(cwv[1]), .cw_ready(cw_rdy[1]), .cw_addr(cwa[1]), .cw_data(cwd[1])
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick(int m);
    if (m == 1) begin
      foreach (mq[m][i]) if (mq[m][i].h) return i;
    end
    return 0;
  endfunction

  // One clock: compare both instances against the model, then advance it.
  task automatic step();
    bit dr [2];
    bit en [2];
    int idx [2];
    #1;
    for (int m = 0; m < 2; m++) begin
      int n = mq[m].size();
      bit eh = 1'b0;
      logic [31:0] ed = '0;
      idx[m] = 0;
      check("R1 st_ready", {31'd0, st_rdy[m]}, {31'd0, n < DEPTH});
      check("R2 cw_valid", {31'd0, cwv[m]}, {31'd0, n > 0});
      if (n > 0) begin
        idx[m] = mhold[m] ? midx[m] : pick(m);
        if (both_prev[m]) begin
          check("R8 cw_addr", cwa[m], mq[m][idx[m]].a);
          check("R8 cw_data", cwd[m], mq[m][idx[m]].d);
        end else if (m == 0) begin
          check("R4 cw_addr", cwa[m], mq[m][idx[m]].a);
          check("R4 cw_data", cwd[m], mq[m][idx[m]].d);
        end else begin
          check("R5 cw_addr", cwa[m], mq[m][idx[m]].a);
          check("R5 cw_data", cwd[m], mq[m][idx[m]].d);
        end
      end
      foreach (mq[m][i]) if (mq[m][i].a == ld_addr) begin eh = 1'b1; ed = mq[m][i].d; end
      check(eh ? "R3 ld_hit" : "R9 ld_hit", {31'd0, ldh[m]}, {31'd0, eh});
      check(eh ? "R3 ld_data" : "R9 ld_data", ldd[m], ed);
      check("R6 fence_stall", {31'd0, fst[m]}, {31'd0, fence_req && n > 0});
      dr[m] = (n > 0) && cw_rdy[m];
      en[m] = st_valid && (n < DEPTH);
    end
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      mhold[m] = (mq[m].size() > 0) && !dr[m];
      midx[m]  = idx[m];
      if (dr[m]) mq[m].delete(idx[m]);
      if (en[m]) mq[m].push_back('{a: st_addr, d: st_data, h: st_hint});
      both_prev[m] = dr[m] && en[m];
    end
    @(negedge clk);
  endtask

  task automatic drive_store(bit v, int slot);
    st_valid = v;
    st_addr  = 32'(slot * 4);
    st_data  = $urandom;
    st_hint  = $urandom_range(0, 1) == 1;
  endtask

  initial begin
    cw_rdy[0] = 1'b0; cw_rdy[1] = 1'b0;
    for (int m = 0; m < 2; m++) begin mhold[m] = 0; midx[m] = 0; both_prev[m] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fence_req = 1'b1;
    #1;
    // R7: empty after reset, fence passes straight through.
    for (int m = 0; m < 2; m++) begin
      check("R7 st_ready", {31'd0, st_rdy[m]}, 32'd1);
      check("R7 cw_valid", {31'd0, cwv[m]}, 32'd0);
      check("R7 ld_hit", {31'd0, ldh[m]}, 32'd0);
      check("R7 fence_stall", {31'd0, fst[m]}, 32'd0);
    end
    fence_req = 1'b0;

    // Fill with the cache stalled; repeated addresses and a full buffer.
    for (int c = 0; c < 12; c++) begin
      drive_store(1'b1, c % 3);
      ld_addr = 32'(($urandom_range(0, 3)) * 4);
      step();
    end

    // Fence with an intermittent cache, no new stores.
    st_valid  = 1'b0;
    fence_req = 1'b1;
    for (int c = 0; c < 30; c++) begin
      cw_rdy[0] = $urandom_range(0, 2) == 0;
      cw_rdy[1] = $urandom_range(0, 2) == 0;
      ld_addr   = 32'(($urandom_range(0, 3)) * 4);
      step();
    end
    fence_req = 1'b0;

    // Random mix.
    for (int c = 0; c < 4000; c++) begin
      drive_store($urandom_range(0, 9) < 6, $urandom_range(0, 7));
      cw_rdy[0] = $urandom_range(0, 9) < 4;
      cw_rdy[1] = $urandom_range(0, 9) < 4;
      fence_req = $urandom_range(0, 15) == 0;
      ld_addr   = 32'(($urandom_range(0, 7)) * 4);
      step();
    end

    // Store and drain in the same cycles.
    fence_req = 1'b0;
    cw_rdy[0] = 1'b1; cw_rdy[1] = 1'b1;
    for (int c = 0; c < 40; c++) begin
      drive_store(1'b1, $urandom_range(0, 7));
      ld_addr = 32'(($urandom_range(0, 7)) * 4);
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule